// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits at the very front of an instruction decoder. It looks at one 32-bit fetch word and decides from its two lowest bits whether the word is a full-width instruction or carries a 16-bit compressed instruction in its lower half. A full-width instruction goes through untouched. A compressed instruction is rewritten into the equivalent full-width base encoding, so the rest of the decoder only ever handles one format.

The compressed subset covered here is small: the register add, the shift left by an immediate, the word load with a scaled offset, and the indirect jump through a register. A compressed form carries only two register operands, so the destination also serves as the first source. The jump expands into an indirect jump whose link result is thrown away. Every other 16-bit encoding raises an illegal flag and zeroes the output word. Each supported form has an elaboration option that removes it; a removed form then reads as illegal.

The path is purely combinational. It has no clock and no state.

Top module: `cx_expander`

## Requirements
- R1: When instr_i[1:0] is 2'b11, instr_o equals instr_i, compressed_o is 0 and illegal_o is 0.
- R2: When instr_i[1:0] is not 2'b11, compressed_o is 1 and only instr_i[15:0] affects the outputs; instr_i[31:16] has no effect.
- R3: A halfword with [1:0]=10, [15:12]=1001, r=[11:7]≠0 and s=[6:2]≠0 expands to ADD r,r,s: {7'b0, s, r, 3'b000, r, 7'b0110011}.
- R4: A halfword with [1:0]=10, [15:12]=1000, r=[11:7]≠0 and [6:2]=0 expands to JALR x0,0(r): {12'b0, r, 3'b000, 5'b0, 7'b1100111}.
- R5: A halfword with [1:0]=10, [15:13]=000, [12]=0, r=[11:7]≠0 and sh=[6:2] expands to SLLI r,r,sh: {7'b0, sh, r, 3'b001, r, 7'b0010011}.
- R6: A halfword with [1:0]=00 and [15:13]=010 expands to LW: the destination is 8+[4:2], the base is 8+[9:7], and the offset is {[5],[12:10],[6],2'b00}, zero-extended. The result is {offset[11:0], base, 3'b010, dest, 7'b0000011}.
- R7: Any other compressed halfword sets illegal_o to 1 and drives instr_o to zero. This covers quadrant 01, the all-zero halfword, and a halfword with [15:12]=1000 and [6:2]≠0.
- R8: The rd=0 or rs1=0 versions of the forms in R3, R4 and R5 are illegal, and so is a shift with [12]=1. All of these follow R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Fetch word; its lower half holds a compressed instruction when bits [1:0] are not 11 |
| instr_o | output | 32 | Full-width instruction: passed through, expanded, or zero when illegal |
| compressed_o | output | 1 | High when the input was taken as a compressed instruction |
| illegal_o | output | 1 | High for a compressed encoding outside the supported subset |

## Verification
The embedded checks assume that instr_i is settled and fully known whenever they evaluate. They also assume that the default parameters leave every form enabled, so a field pattern listed in a requirement always yields a legal expansion. The bench keeps to these assumptions. It changes the input only on the falling clock edge and holds it fully defined. Its random words are either raw 32-bit values or halfwords built field by field for the supported forms, with the upper half filled with noise. Directed cases cover the zero-register exclusions, the reserved shift bit, the largest load offset and the neighbouring register-move encoding.

// File: rtl/cx_pkg.sv
package cx_pkg;
   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_OPIMM = 7'b0010011;
   localparam logic [6:0] OPC_OP    = 7'b0110011;
   localparam logic [6:0] OPC_JALR  = 7'b1100111;

   localparam logic [2:0] F3_ADD  = 3'b000;
   localparam logic [2:0] F3_SLL  = 3'b001;
   localparam logic [2:0] F3_WORD = 3'b010;
   localparam logic [2:0] F3_JALR = 3'b000;

   localparam logic [1:0] QUAD_MEM = 2'b00;
   localparam logic [1:0] QUAD_ALU = 2'b01;
   localparam logic [1:0] QUAD_REG = 2'b10;
   localparam logic [1:0] QUAD_FULL = 2'b11;

   typedef struct packed {
      logic        legal;
      logic [31:0] word;
   } cx_exp_t;
endpackage

// File: rtl/cx_load_expand.sv
module cx_load_expand
   import cx_pkg::*;
#(
   parameter int CLEN      = 16,
   parameter int REG_W     = 5,
   parameter int CREG_W    = 3,
   parameter int CREG_BASE = 8,
   parameter bit EN_LOAD   = 1'b1
) (
   input  logic [CLEN-1:0] half_i,
   output cx_exp_t         res_o
);
   localparam int IMM_W = 12;
   localparam int NREG  = 1 << REG_W;
   localparam int NCREG = 1 << CREG_W;

   if (CREG_BASE + NCREG > NREG) begin : g_bad_base
      $error("cx_load_expand: compact register window exceeds register file");
   end

   logic               hit;
   logic [CREG_W-1:0]  rd_c;
   logic [CREG_W-1:0]  rs_c;
   logic [REG_W-1:0]   rd_f;
   logic [REG_W-1:0]   rs_f;
   logic [IMM_W-1:0]   ofs;

   always_comb begin
      hit  = (half_i[1:0] == QUAD_MEM) && (half_i[15:13] == F3_WORD);
      rd_c = half_i[4:2];
      rs_c = half_i[9:7];
      rd_f = REG_W'(CREG_BASE) + REG_W'(rd_c);
      rs_f = REG_W'(CREG_BASE) + REG_W'(rs_c);
      ofs  = '0;
      ofs[6]   = half_i[5];
      ofs[5:3] = half_i[12:10];
      ofs[2]   = half_i[6];
   end

   if (EN_LOAD) begin : g_load_on
      always_comb begin
         res_o.legal = hit;
         res_o.word  = hit ? {ofs, rs_f, F3_WORD, rd_f, OPC_LOAD} : '0;
         if (res_o.legal) begin
            a_r6_base_in_window: assert (res_o.word[19:15] >= REG_W'(CREG_BASE)
                                         && res_o.word[11:7] >= REG_W'(CREG_BASE))
               else $error("R6 load register outside compact window");
            a_r6_word_aligned: assert (res_o.word[21:20] == 2'b00)
               else $error("R6 load offset not word aligned");
         end
      end
   end else begin : g_load_off
      always_comb begin
         res_o.legal = 1'b0;
         res_o.word  = '0;
      end
   end
endmodule

// File: rtl/cx_reg_expand.sv
module cx_reg_expand
   import cx_pkg::*;
#(
   parameter int CLEN    = 16,
   parameter int REG_W   = 5,
   parameter int SHAMT_W = 5,
   parameter bit EN_ADD  = 1'b1,
   parameter bit EN_SLLI = 1'b1,
   parameter bit EN_JR   = 1'b1
) (
   input  logic [CLEN-1:0] half_i,
   output cx_exp_t         res_o
);
   if (SHAMT_W != REG_W) begin : g_bad_shamt
      $error("cx_reg_expand: shift amount field must match register field");
   end

   logic             in_quad;
   logic [REG_W-1:0] rd;
   logic [REG_W-1:0] rs2;
   logic             add_hit, jr_hit, sl_hit;
   logic             add_ok, jr_ok, sl_ok;
   logic [31:0]      add_w, jr_w, sl_w;

   always_comb begin
      in_quad = (half_i[1:0] == QUAD_REG);
      rd      = half_i[11:7];
      rs2     = half_i[6:2];
      add_hit = in_quad && (half_i[15:12] == 4'b1001) && (rd != '0) && (rs2 != '0);
      jr_hit  = in_quad && (half_i[15:12] == 4'b1000) && (rd != '0) && (rs2 == '0);
      sl_hit  = in_quad && (half_i[15:13] == 3'b000) && !half_i[12] && (rd != '0);
   end

   if (EN_ADD) begin : g_add_on
      assign add_ok = add_hit;
      assign add_w  = {7'b0, rs2, rd, F3_ADD, rd, OPC_OP};
   end else begin : g_add_off
      assign add_ok = 1'b0;
      assign add_w  = '0;
   end

   if (EN_JR) begin : g_jr_on
      assign jr_ok = jr_hit;
      assign jr_w  = {12'b0, rd, F3_JALR, 5'b0, OPC_JALR};
   end else begin : g_jr_off
      assign jr_ok = 1'b0;
      assign jr_w  = '0;
   end

   if (EN_SLLI) begin : g_sl_on
      assign sl_ok = sl_hit;
      assign sl_w  = {7'b0, SHAMT_W'(rs2), rd, F3_SLL, rd, OPC_OPIMM};
   end else begin : g_sl_off
      assign sl_ok = 1'b0;
      assign sl_w  = '0;
   end

   always_comb begin
      res_o.legal = add_ok | jr_ok | sl_ok;
      res_o.word  = '0;
      if (add_ok)     res_o.word = add_w;
      else if (jr_ok) res_o.word = jr_w;
      else if (sl_ok) res_o.word = sl_w;

      a_r3_dest_is_source: assert (!add_ok || (res_o.word[19:15] == res_o.word[11:7]))
         else $error("R3 add destination differs from first source");
      a_r4_link_discarded: assert (!jr_ok || (res_o.word[11:7] == '0 && res_o.word[31:20] == '0))
         else $error("R4 jump writes a link register or has offset");
      a_r8_no_zero_dest: assert (!res_o.legal || (rd != '0))
         else $error("R8 legal expansion with zero register field");
      a_r5_single_form: assert ($countones({add_ok, jr_ok, sl_ok}) <= 1)
         else $error("R5 overlapping register-quadrant forms");
   end
endmodule

// File: rtl/cx_expander.sv
module cx_expander
   import cx_pkg::*;
#(
   parameter int ILEN      = 32,
   parameter int CLEN      = 16,
   parameter int REG_W     = 5,
   parameter int CREG_W    = 3,
   parameter int CREG_BASE = 8,
   parameter bit EN_LOAD   = 1'b1,
   parameter bit EN_ADD    = 1'b1,
   parameter bit EN_SLLI   = 1'b1,
   parameter bit EN_JR     = 1'b1
) (
   input  logic [ILEN-1:0] instr_i,
   output logic [ILEN-1:0] instr_o,
   output logic            compressed_o,
   output logic            illegal_o
);
   localparam int SHAMT_W = REG_W;

   if (ILEN != 2 * CLEN || ILEN != 32) begin : g_bad_len
      $error("cx_expander: fetch word must hold exactly two 16-bit halves");
   end

   logic [CLEN-1:0] half;
   cx_exp_t         mem_res;
   cx_exp_t         reg_res;
   cx_exp_t         sel;

   assign half = instr_i[CLEN-1:0];

   cx_load_expand #(
      .CLEN(CLEN), .REG_W(REG_W), .CREG_W(CREG_W),
      .CREG_BASE(CREG_BASE), .EN_LOAD(EN_LOAD)
   ) u_mem (
      .half_i(half),
      .res_o (mem_res)
   );

   cx_reg_expand #(
      .CLEN(CLEN), .REG_W(REG_W), .SHAMT_W(SHAMT_W),
      .EN_ADD(EN_ADD), .EN_SLLI(EN_SLLI), .EN_JR(EN_JR)
   ) u_reg (
      .half_i(half),
      .res_o (reg_res)
   );

   always_comb begin
      case (half[1:0])
         QUAD_MEM: sel = mem_res;
         QUAD_REG: sel = reg_res;
         default:  sel = '0;
      endcase

      compressed_o = (half[1:0] != QUAD_FULL);
      if (!compressed_o) begin
         instr_o   = instr_i;
         illegal_o = 1'b0;
      end else if (sel.legal) begin
         instr_o   = sel.word;
         illegal_o = 1'b0;
      end else begin
         instr_o   = '0;
         illegal_o = 1'b1;
      end

      a_r1_full_never_illegal: assert (compressed_o || !illegal_o)
         else $error("R1 full-width word flagged illegal");
      a_r7_zero_on_illegal: assert (!illegal_o || (instr_o == '0))
         else $error("R7 illegal output word not zero");
      a_r2_expanded_is_full: assert (!compressed_o || illegal_o || (instr_o[1:0] == QUAD_FULL))
         else $error("R2 expansion is not a full-width encoding");
      a_r7_quad1_illegal: assert (half[1:0] != QUAD_ALU || illegal_o)
         else $error("R7 quadrant 01 accepted");
   end
endmodule

// File: tb/sim_cx_expander.sv
module sim_cx_expander;
   logic        clk = 1'b0;
   logic [31:0] instr;
   logic [31:0] out_w;
   logic        out_c;
   logic        out_il;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   cx_expander u0 (
      .instr_i     (instr),
      .instr_o     (out_w),
      .compressed_o(out_c),
      .illegal_o   (out_il)
   );

   function automatic void model(input logic [31:0] w, output logic [31:0] ew,
                                 output bit ec, output bit eil, output string tag);
      logic [15:0] h = w[15:0];
      int r  = int'(h[11:7]);
      int s  = int'(h[6:2]);
      ew = 32'h0; eil = 1'b1; ec = 1'b1; tag = "R7";
      if (h[1:0] == 2'b11) begin
         ew = w; ec = 1'b0; eil = 1'b0; tag = "R1";
      end else if (h[1:0] == 2'b00 && h[15:13] == 3'd2) begin
         int ofs = int'(h[5]) * 64 + int'(h[12:10]) * 8 + int'(h[6]) * 4;
         int dst = int'(h[4:2]) + 8;
         int bas = int'(h[9:7]) + 8;
         ew = (32'(ofs) << 20) | (32'(bas) << 15) | (32'd2 << 12) | (32'(dst) << 7) | 32'd3;
         eil = 1'b0; tag = "R6";
      end else if (h[1:0] == 2'b10) begin
         if (h[15:12] == 4'd9) begin
            if (r != 0 && s != 0) begin
               ew = (32'(s) << 20) | (32'(r) << 15) | (32'(r) << 7) | 32'h33;
               eil = 1'b0; tag = "R3";
            end else tag = "R8";
         end else if (h[15:12] == 4'd8) begin
            if (s == 0 && r != 0) begin
               ew = (32'(r) << 15) | 32'h67; eil = 1'b0; tag = "R4";
            end else if (s == 0) tag = "R8";
         end else if (h[15:13] == 3'd0) begin
            if (r != 0 && h[12] == 1'b0) begin
               ew = (32'(s) << 20) | (32'(r) << 15) | (32'd1 << 12) | (32'(r) << 7) | 32'h13;
               eil = 1'b0; tag = "R5";
            end else tag = "R8";
         end
      end
   endfunction

   task automatic apply(input logic [31:0] w, input string note);
      logic [31:0] ew; bit ec; bit eil; string tag;
      model(w, ew, ec, eil, tag);
      @(negedge clk);
      instr = w;
      @(posedge clk);
      checks++;
      if (out_w !== ew || out_c !== ec || out_il !== eil) begin
         errors++;
         $display("FAIL %s (%s) in=%h actual w=%h c=%b il=%b expected w=%h c=%b il=%b",
                  tag, note, w, out_w, out_c, out_il, ew, ec, eil);
      end
   endtask

   function automatic logic [31:0] build(input int kind);
      logic [31:0] up = $urandom;
      logic [15:0] h;
      logic [4:0] r = 5'($urandom_range(31, 1));
      logic [4:0] s = 5'($urandom_range(31, 1));
      case (kind)
         0: h = {4'b1001, r, s, 2'b10};
         1: h = {4'b1000, r, 5'd0, 2'b10};
         2: h = {3'b000, 1'b0, r, 5'($urandom), 2'b10};
         3: h = {3'b010, 13'($urandom) & 13'h1FFC};
         default: h = 16'($urandom);
      endcase
      return {up[31:16], h};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1c0de5));
      instr = 32'h0;
      // initial state: all-zero halfword is illegal (R7)
      apply(32'h0000_0000, "R7 all-zero halfword");
      apply(32'hFFFF_FFFF, "R1 all ones pass");
      apply(32'h0050_0513, "R1 full-width addi");
      apply(32'hDEAD_908A, "R2 R3 add x1,x2 with upper noise");
      apply(32'h0000_9FFE, "R3 add x31,x31");
      apply(32'h1234_8082, "R4 jr x1");
      apply(32'h0000_8F82, "R4 jr x31");
      apply(32'h0000_0FFE, "R5 slli x31 by 31");
      apply(32'h0000_1086, "R8 slli reserved bit12");
      apply(32'h0000_0006, "R8 slli rd zero");
      apply(32'h0000_900A, "R8 add rd zero");
      apply(32'h0000_8002, "R8 jr rs1 zero");
      apply(32'h0000_808A, "R7 register move unsupported");
      apply(32'h0000_0505, "R7 quadrant 01");
      apply(32'h0000_5FFC, "R6 lw max offset x15");
      apply(32'hABCD_4000, "R6 lw zero offset x8");
      apply(32'h5555_9FFE, "R2 upper noise A");
      apply(32'hAAAA_9FFE, "R2 upper noise B");
      for (int i = 0; i < 2000; i++) begin
         int k = $urandom_range(5, 0);
         logic [31:0] w = (k == 5) ? 32'($urandom) : build(k);
         apply(w, "random");
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule